// File: doc/BRIEF.md
# Triggered Multi-Event Sample Buffer

This block records bursts of 10-bit samples from one converter channel into a 1024-word, 40-bit event memory. A first-level trigger opens a capture. The capture runs until a set number of valid-qualified input samples has been seen. The samples are packed four to a word, and a header word with the trigger timestamp and the stored sample count is written in front of them.

A captured event then waits for a second-level decision. An accept commits the event to the readout queue. A reject frees its slot. A new first-level trigger that arrives before any decision overwrites the waiting event.

The memory is split into equal slots. In raw mode every sample is stored as it arrives and there are four slots. In zero-suppressed mode only samples at or above a threshold are stored and there are eight slots. Committed events leave on a 40-bit valid/ready output, oldest first: the header, then the data words.

Top module: `evt_capture_buf`

## Requirements
- R1: After reset, `out_valid` and `overflow` are 0 and no event is queued.
- R2: The header word holds the stored sample count in bits [10:0] and, in bits [34:11], the value of a free-running cycle counter at the trigger edge. Bits [39:35] are 0. The cycle counter is 0 on the first clock edge after reset and counts up by one on every edge. Data word k holds stored samples 4k to 4k+3, with sample j in bits [10*(j mod 4)+9 : 10*(j mod 4)]. Unused lanes of the last word are zero.
- R3: A capture ends after `cfg_len` valid samples. A `cfg_len` of 0, or any value above 1008, means 1008 samples.
- R4: The readout of an accepted event is its header word followed by its data words in order, one word per cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R5: `l2_reject` on a waiting event discards it, and nothing from that event is ever read out.
- R6: A first-level trigger on a waiting event drops that event and starts a new capture with a new timestamp. Only the new event can later be committed.
- R7: In raw mode (`cfg_zs`=0) four committed events can be held. A trigger that arrives while the block is idle and all slots are committed starts nothing and sets `overflow`, which stays 1 until reset.
- R8: In zero-suppressed mode (`cfg_zs`=1) only samples greater than or equal to `cfg_thresh` are stored, eight slots are available, and at most 508 samples are stored per event. Further samples still count toward the stream length.
- R9: Committed events are read out in the order in which they were committed.
- R10: A first-level trigger or a second-level accept that arrives during a capture is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_zs | input | 1 | 1 = zero suppression with 8 slots, 0 = raw with 4 slots; change only while empty |
| cfg_thresh | input | 10 | Suppression threshold |
| cfg_len | input | 11 | Samples per capture (0 or above 1008 = 1008) |
| l1_trig | input | 1 | First-level trigger pulse |
| l2_accept | input | 1 | Second-level accept pulse |
| l2_reject | input | 1 | Second-level reject pulse |
| s_valid | input | 1 | Input sample qualifier |
| s_data | input | 10 | Input sample |
| out_valid | output | 1 | Readout word available |
| out_data | output | 40 | Readout word |
| out_ready | input | 1 | Readout consumer ready |
| overflow | output | 1 | Sticky: a trigger found no free slot |

## Verification
A slot counter that drifts shows up at once as a word-count mismatch at the output. It appears either as a missing event or as an event read twice, and it shows within the first drain after the fault. Wrong packing or header state is visible in the very first word pair of the affected event. A wrongly kept pending event produces surplus readout words right after the accept or reject that should have cleared it. Overflow and slot-count errors appear only when the slots fill, so the sweeps fill every slot in both modes before reading.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {W_IDLE, W_CAP, W_HDR, W_PEND} wr_state_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned clamp_len(int unsigned cfg, int unsigned maxl);
    return (cfg == 0 || cfg > maxl) ? maxl : cfg;
  endfunction
endpackage

// File: rtl/evt_slots.sv
module evt_slots #(
  parameter int NSLOT_RAW = 4,
  parameter int NSLOT_ZS  = 8,
  parameter int SLOT_W    = 3,
  parameter int USED_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_zs,
  input  logic              commit,
  input  logic              release_evt,
  output logic [USED_W-1:0] used,
  output logic [USED_W-1:0] nslots,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              slot_free,
  output logic              have_evt
);
  logic [SLOT_W-1:0] mask;

  assign nslots    = cfg_zs ? USED_W'(NSLOT_ZS) : USED_W'(NSLOT_RAW);
  assign mask      = SLOT_W'(nslots - USED_W'(1));
  assign wr_slot   = (rd_slot + SLOT_W'(used)) & mask;
  assign slot_free = used < nslots;
  assign have_evt  = used != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used    <= '0;
      rd_slot <= '0;
    end else begin
      used <= used + USED_W'(commit) - USED_W'(release_evt);
      if (release_evt) rd_slot <= (rd_slot + SLOT_W'(1)) & mask;
    end
  end
endmodule

// File: rtl/evt_writer.sv
module evt_writer #(
  parameter int SAMPLE_W = 10,
  parameter int WORD_W   = 40,
  parameter int AW       = 10,
  parameter int TS_W     = 24,
  parameter int MAX_LEN  = 1008,
  parameter int LEN_W    = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_zs,
  input  logic [SAMPLE_W-1:0] cfg_thresh,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                l1_trig,
  input  logic                l2_accept,
  input  logic                l2_reject,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic [TS_W-1:0]     ts_now,
  input  logic                slot_free,
  input  logic [AW-1:0]       slot_base,
  input  logic [LEN_W-1:0]    slot_cap,
  output logic                we,
  output logic [AW-1:0]       waddr,
  output logic [WORD_W-1:0]   wdata,
  output logic                commit,
  output logic                overflow
);
  import evt_pkg::*;
  localparam int LANES  = WORD_W / SAMPLE_W;
  localparam int LANE_W = $clog2(LANES);

  function automatic logic [WORD_W-1:0] place(logic [WORD_W-1:0] w,
                                              logic [SAMPLE_W-1:0] s,
                                              logic [LANE_W-1:0] ln);
    logic [WORD_W-1:0] r;
    r = w;
    r[int'(ln)*SAMPLE_W +: SAMPLE_W] = s;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] make_hdr(logic [TS_W-1:0] t,
                                                 logic [LEN_W-1:0] c);
    logic [WORD_W-1:0] r;
    r = '0;
    r[LEN_W-1:0] = c;
    r[LEN_W +: TS_W] = t;
    return r;
  endfunction

  wr_state_e          st;
  logic [LEN_W-1:0]   in_cnt, st_cnt, len_q;
  logic [LANE_W-1:0]  lane;
  logic [AW-1:0]      widx, base_q;
  logic [WORD_W-1:0]  pack, merged;
  logic [TS_W-1:0]    ts_q;
  logic               start, keep, last, flush;

  assign start  = l1_trig && ((st == W_IDLE && slot_free) ||
                              (st == W_PEND && !l2_accept && !l2_reject));
  assign keep   = s_valid && (!cfg_zs || s_data >= cfg_thresh) && (st_cnt < slot_cap);
  assign last   = s_valid && ((in_cnt + LEN_W'(1)) == len_q);
  assign merged = keep ? place(pack, s_data, lane) : pack;
  assign flush  = (keep && lane == LANE_W'(LANES - 1)) || (last && (keep || lane != '0));
  assign commit = (st == W_PEND) && l2_accept;

  always_comb begin
    we    = 1'b0;
    waddr = base_q + AW'(1) + widx;
    wdata = merged;
    if (st == W_CAP && flush) we = 1'b1;
    if (st == W_HDR) begin
      we    = 1'b1;
      waddr = base_q;
      wdata = make_hdr(ts_q, st_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      in_cnt   <= '0;
      st_cnt   <= '0;
      len_q    <= '0;
      lane     <= '0;
      widx     <= '0;
      base_q   <= '0;
      pack     <= '0;
      ts_q     <= '0;
      overflow <= 1'b0;
    end else begin
      if (st == W_IDLE && l1_trig && !slot_free) overflow <= 1'b1;
      if (start) begin
        st     <= W_CAP;
        in_cnt <= '0;
        st_cnt <= '0;
        lane   <= '0;
        widx   <= '0;
        pack   <= '0;
        base_q <= slot_base;
        ts_q   <= ts_now;
        len_q  <= LEN_W'(clamp_len(int'(cfg_len), MAX_LEN));
      end else begin
        case (st)
          W_CAP: if (s_valid) begin
            in_cnt <= in_cnt + LEN_W'(1);
            if (keep) st_cnt <= st_cnt + LEN_W'(1);
            if (flush) begin
              pack <= '0;
              lane <= '0;
              widx <= widx + AW'(1);
            end else if (keep) begin
              pack <= merged;
              lane <= lane + LANE_W'(1);
            end
            if (last) st <= W_HDR;
          end
          W_HDR:  st <= W_PEND;
          W_PEND: if (l2_accept || l2_reject) st <= W_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_reader.sv
module evt_reader #(
  parameter int AW    = 10,
  parameter int LEN_W = 11,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             have_evt,
  input  logic [LEN_W-1:0] hdr_cnt,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [AW-1:0]    rd_idx,
  output logic             release_evt
);
  logic [AW-1:0] last_idx;

  assign last_idx    = AW'(evt_pkg::ceil_div(int'(hdr_cnt), LANES));
  assign out_valid   = have_evt;
  assign release_evt = have_evt && out_ready && (rd_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_idx <= '0;
    else if (out_valid && out_ready) rd_idx <= release_evt ? '0 : rd_idx + AW'(1);
  end
endmodule

// File: rtl/evt_capture_buf.sv
module evt_capture_buf #(
  parameter int SAMPLE_W  = 10,
  parameter int WORD_W    = 40,
  parameter int DEPTH     = 1024,
  parameter int MAX_LEN   = 1008,
  parameter int TS_W      = 24,
  parameter int NSLOT_RAW = 4,
  parameter int NSLOT_ZS  = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_zs,
  input  logic [SAMPLE_W-1:0]                 cfg_thresh,
  input  logic [$clog2(MAX_LEN+1):0]          cfg_len,
  input  logic                                l1_trig,
  input  logic                                l2_accept,
  input  logic                                l2_reject,
  input  logic                                s_valid,
  input  logic [SAMPLE_W-1:0]                 s_data,
  output logic                                out_valid,
  output logic [WORD_W-1:0]                   out_data,
  input  logic                                out_ready,
  output logic                                overflow
);
  localparam int AW     = $clog2(DEPTH);
  localparam int LANES  = WORD_W / SAMPLE_W;
  localparam int LEN_W  = $clog2(MAX_LEN + 1) + 1;
  localparam int SLOT_W = $clog2(NSLOT_ZS);
  localparam int USED_W = $clog2(NSLOT_ZS + 1);
  localparam int WORDS_RAW = DEPTH / NSLOT_RAW;
  localparam int WORDS_ZS  = DEPTH / NSLOT_ZS;

  function automatic logic [AW-1:0] slot_base(logic [SLOT_W-1:0] s, logic zs);
    return AW'(int'(s) * (zs ? WORDS_ZS : WORDS_RAW));
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic              mem_we, commit, release_evt, slot_free, have_evt;
  logic [AW-1:0]     mem_waddr, wr_base, rd_base, rd_idx;
  logic [WORD_W-1:0] mem_wdata;
  logic [USED_W-1:0] used, nslots;
  logic [SLOT_W-1:0] rd_slot, wr_slot;
  logic [AW:0]       slot_words;
  logic [LEN_W-1:0]  slot_cap, hdr_cnt;
  logic [TS_W-1:0]   ts_now;

  assign slot_words = cfg_zs ? (AW+1)'(WORDS_ZS) : (AW+1)'(WORDS_RAW);
  assign slot_cap   = cfg_zs ? LEN_W'((WORDS_ZS - 1) * LANES) : LEN_W'((WORDS_RAW - 1) * LANES);
  assign wr_base    = slot_base(wr_slot, cfg_zs);
  assign rd_base    = slot_base(rd_slot, cfg_zs);
  assign hdr_cnt    = mem[rd_base][LEN_W-1:0];
  assign out_data   = mem[rd_base + rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_now <= '0;
    else        ts_now <= ts_now + TS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  evt_slots #(.NSLOT_RAW(NSLOT_RAW), .NSLOT_ZS(NSLOT_ZS), .SLOT_W(SLOT_W), .USED_W(USED_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .cfg_zs(cfg_zs), .commit(commit), .release_evt(release_evt),
    .used(used), .nslots(nslots), .rd_slot(rd_slot), .wr_slot(wr_slot),
    .slot_free(slot_free), .have_evt(have_evt));

  evt_writer #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .AW(AW), .TS_W(TS_W),
               .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .cfg_zs(cfg_zs), .cfg_thresh(cfg_thresh), .cfg_len(cfg_len),
    .l1_trig(l1_trig), .l2_accept(l2_accept), .l2_reject(l2_reject),
    .s_valid(s_valid), .s_data(s_data), .ts_now(ts_now), .slot_free(slot_free),
    .slot_base(wr_base), .slot_cap(slot_cap), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .commit(commit), .overflow(overflow));

  evt_reader #(.AW(AW), .LEN_W(LEN_W), .LANES(LANES)) u_reader (
    .clk(clk), .rst_n(rst_n), .have_evt(have_evt), .hdr_cnt(hdr_cnt),
    .out_ready(out_ready), .out_valid(out_valid), .rd_idx(rd_idx),
    .release_evt(release_evt));
endmodule

// File: rtl/evt_capture_buf_chk.sv
module evt_capture_buf_chk #(
  parameter int AW     = 10,
  parameter int WORD_W = 40,
  parameter int USED_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [USED_W-1:0] used,
  input logic [USED_W-1:0] nslots,
  input logic              commit,
  input logic              mem_we,
  input logic [AW-1:0]     mem_waddr,
  input logic [AW-1:0]     wr_base,
  input logic [AW:0]       slot_words,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              overflow
);
  assert_used_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    used <= nslots);

  assert_commit_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> used < nslots);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(overflow));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_wr_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_waddr} >= {1'b0, wr_base} &&
                {1'b0, mem_waddr} <  {1'b0, wr_base} + slot_words));
endmodule

bind evt_capture_buf evt_capture_buf_chk #(.AW(AW), .WORD_W(WORD_W), .USED_W(USED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .used(used), .nslots(nslots), .commit(commit),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .wr_base(wr_base), .slot_words(slot_words),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .overflow(overflow));

// File: tb/tb_evt_capture_buf.sv
module tb_evt_capture_buf;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, cfg_zs = 1'b0;
  logic [9:0]  cfg_thresh = '0, s_data = '0;
  logic [10:0] cfg_len = '0;
  logic        l1_trig = 0, l2_accept = 0, l2_reject = 0, s_valid = 0, out_ready = 0;
  logic        out_valid, overflow;
  logic [39:0] out_data;

  evt_capture_buf dut (.*);

  int n_tests = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
  bit done = 0;
  logic [39:0] expq[$], got[$], pendq[$];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] smp(int e, int j);
    return 10'((e * 37 + j * 13 + 5) % 1024);
  endfunction

  // readout driver and monitor, R4 hold check
  initial begin
    bit pv = 0;
    logic [39:0] pd = '0;
    forever begin
      @(negedge clk);
      if (pv) chk(out_valid && out_data === pd, "R4", "held word", out_data, pd);
      out_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? ~out_ready : 1'b0;
      pv = out_valid && !out_ready;
      pd = out_data;
      if (out_valid && out_ready) got.push_back(out_data);
    end
  end

  task automatic do_reset(bit zs, int thr);
    rst_n = 0; cfg_zs = zs; cfg_thresh = 10'(thr); rdy_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expq.delete(); got.delete(); pendq.delete();
    @(negedge clk);
  endtask

  task automatic capture(int cfg_l, int e, bit gaps, bit zs, int thr, bit stray);
    int n, ts, st, lane, cap;
    logic [39:0] w;
    n   = (cfg_l == 0 || cfg_l > 1008) ? 1008 : cfg_l;
    cap = zs ? 508 : 1020;
    cfg_len = 11'(cfg_l);
    @(negedge clk);
    l1_trig = 1; ts = cyc;
    @(negedge clk);
    l1_trig = 0;
    pendq.delete(); w = '0; st = 0; lane = 0;
    for (int j = 0; j < n; j++) begin
      s_valid = 1; s_data = smp(e, j);
      if (stray && j == 2) begin l1_trig = 1; l2_accept = 1; end
      if ((!zs || int'(smp(e, j)) >= thr) && st < cap) begin
        w[lane*10 +: 10] = smp(e, j);
        st++; lane++;
        if (lane == 4) begin pendq.push_back(w); w = '0; lane = 0; end
      end
      @(negedge clk);
      l1_trig = 0; l2_accept = 0;
      if (gaps && j % 3 == 0) begin s_valid = 0; @(negedge clk); end
    end
    s_valid = 0;
    if (lane != 0) pendq.push_back(w);
    pendq.push_front({5'b0, 24'(ts), 11'(st)});
    @(negedge clk);
  endtask

  task automatic accept();
    l2_accept = 1; @(negedge clk); l2_accept = 0;
    foreach (pendq[i]) expq.push_back(pendq[i]);
  endtask

  task automatic reject();
    l2_reject = 1; @(negedge clk); l2_reject = 0;
  endtask

  task automatic drain(int mode, string req);
    int t = 0;
    rdy_mode = mode;
    while (got.size() < expq.size() && t < 5000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    rdy_mode = 0;
    @(negedge clk);
    chk(got.size() == expq.size(), req, "word count", got.size(), expq.size());
    for (int i = 0; i < expq.size() && i < got.size(); i++)
      chk(got[i] === expq[i], req, $sformatf("word %0d", i), got[i], expq[i]);
    expq.delete(); got.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(0, 0);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(overflow == 0, "R1", "overflow after reset", overflow, 0);

    // R2: length sweep across full and partial words, raw mode
    for (int l = 1; l <= 9; l++) begin
      capture(l, l, 0, 0, 0, 0); accept(); drain(1, "R2");
    end
    // R3: zero and oversize lengths mean 1008
    capture(0, 11, 0, 0, 0, 0); accept(); drain(1, "R3");
    capture(2000, 12, 0, 0, 0, 0); accept(); drain(2, "R3");
    // R4: gapped input, toggling ready
    capture(13, 13, 1, 0, 0, 0); accept(); drain(2, "R4");
    // R5: rejected event never appears
    capture(6, 14, 0, 0, 0, 0); reject(); drain(1, "R5");
    capture(5, 15, 0, 0, 0, 0); accept(); drain(1, "R5");
    // R6: new trigger replaces a waiting event
    capture(7, 20, 0, 0, 0, 0);
    capture(9, 21, 0, 0, 0, 0); accept(); drain(1, "R6");
    // R10: trigger and accept during capture are ignored
    capture(8, 22, 0, 0, 0, 1);
    rdy_mode = 1; repeat (6) @(negedge clk);
    chk(got.size() == 0, "R10", "words before accept", got.size(), 0);
    rdy_mode = 0; @(negedge clk);
    accept(); drain(1, "R10");
    // R7 and R9: fill raw slots, then overflow
    for (int k = 0; k < 4; k++) begin
      capture(3 + k, 30 + k, 0, 0, 0, 0); accept();
    end
    l1_trig = 1; @(negedge clk); l1_trig = 0; @(negedge clk);
    chk(overflow == 1, "R7", "overflow when full", overflow, 1);
    for (int j = 0; j < 8; j++) begin s_valid = 1; s_data = 10'(j); @(negedge clk); end
    s_valid = 0;
    drain(1, "R9");
    chk(overflow == 1, "R7", "overflow sticky", overflow, 1);

    // R8: zero suppression, eight slots, capacity cap
    do_reset(1, 300);
    for (int k = 0; k < 8; k++) begin
      capture(10, 40 + k, 0, 1, 300, 0); accept();
    end
    l1_trig = 1; @(negedge clk); l1_trig = 0; @(negedge clk);
    chk(overflow == 1, "R8", "overflow after eight slots", overflow, 1);
    drain(1, "R8");
    do_reset(1, 0);
    capture(0, 50, 0, 1, 0, 0); accept();
    chk(expq.size() == 128, "R8", "expected words at cap", expq.size(), 128);
    drain(2, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule